// File: doc/BRIEF.md
# Twelve-Channel Grayscale PWM Engine

This block turns twelve 16-bit grayscale words into twelve on/off drive signals for LED current sinks. The channels form three colour groups of four: red, green and blue. A single shared 16-bit counter sweeps each PWM period. A channel is driven while the counter is below that channel's grayscale word, so duty cycle scales linearly from fully off (value 0) to 65535 of 65536 steps (value FFFFh).

A one-cycle load strobe copies the grayscale words, three 7-bit group brightness words and four control flags into the block, and restarts the counter at zero. The flags select:
- output suppression;
- continuous cycling or a single period;
- the counter advance source: an internal oscillator tick or an edge of an external shift clock;
- which external clock edge advances the counter.

The three colour groups leave the block on successive system clock cycles, which spreads the switching current. An over-temperature input removes all drive at once. The brightness words are held and exported for the analog current stage. They do not alter the PWM timing.

Top module: `gs_pwm12`

## Requirements
- R1: After reset, every channel output and every exported brightness word is 0.
- R2: The load strobe, sampled on a rising system clock edge, captures the grayscale, brightness and flag inputs and sets the counter to 0. The grayscale bus holds channel i in bits [16i+15:16i]. Channels 0-3 drive out_r[0..3], channels 4-7 drive out_g[0..3] and channels 8-11 drive out_b[0..3]. The brightness bus holds red in bits [6:0], green in [13:7] and blue in [20:14].
- R3: A channel is on exactly while the suppression flag is 0 and the counter is below its grayscale word. A word of 0 is never on, and a word of FFFFh is off only at a count of 65535.
- R4: While the held suppression flag is 1, all outputs are 0 and the counter stays at 0 whatever ticks arrive.
- R5: With the source flag at 1, the counter advances on edges of the external clock and ignores the oscillator tick. With the flag at 0, it advances once for each cycle in which the oscillator tick is high.
- R6: With the edge flag at 1, rising edges of the external clock advance the counter. With the edge flag at 0, falling edges advance it.
- R7: With the repeat flag at 0, a tick at count 65535 stops the counter. All outputs then stay 0 until the next load strobe restarts from 0.
- R8: With the repeat flag at 1, a tick at count 65535 wraps the counter to 0 and the period starts again.
- R9: While the over-temperature input is 1, all outputs are 0 in the same cycle.
- R10: The red outputs follow a counter change one system clock later. Green follows one cycle after red, and blue one cycle after green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| latch_stb | input | 1 | Load strobe for grayscale, brightness and flags |
| gs_in | input | 192 | Twelve 16-bit grayscale words |
| bc_in | input | 21 | Three 7-bit group brightness words |
| ctl_blank | input | 1 | Output suppression flag |
| ctl_repeat | input | 1 | Continuous cycling flag |
| ctl_extclk | input | 1 | 1: advance on the external clock, 0: on the oscillator tick |
| ctl_rise | input | 1 | External clock edge: 1 rising, 0 falling |
| osc_tick | input | 1 | Internal oscillator tick, one system cycle wide |
| sck_in | input | 1 | External shift clock level, synchronous to clk |
| ovt | input | 1 | Over-temperature indication |
| out_r | output | 4 | Red channel drive |
| out_g | output | 4 | Green channel drive |
| out_b | output | 4 | Blue channel drive |
| bc_r | output | 7 | Held red brightness |
| bc_g | output | 7 | Held green brightness |
| bc_b | output | 7 | Held blue brightness |

## Verification
The hardest states to reach are the end of a full 65536-step period and the repeat/single-period decision made there. Reaching count 65535 takes tens of thousands of ticks. The stimulus holds the oscillator tick high for long runs so the counter is walked to 65534, 65535 and one step beyond in both flag settings. The staggered group timing is observed by sampling every system cycle around one counter transition. Edge selection is observed by leaving the external clock high for several cycles before its falling edge.

// File: rtl/gs_pwm12.sv
`timescale 1ns/1ps
module gs_pwm12 #(
  parameter int CPG = 4,
  parameter int GW  = 16,
  parameter int BW  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               latch_stb,
  input  logic [3*CPG*GW-1:0] gs_in,
  input  logic [3*BW-1:0]    bc_in,
  input  logic               ctl_blank,
  input  logic               ctl_repeat,
  input  logic               ctl_extclk,
  input  logic               ctl_rise,
  input  logic               osc_tick,
  input  logic               sck_in,
  input  logic               ovt,
  output logic [CPG-1:0]     out_r,
  output logic [CPG-1:0]     out_g,
  output logic [CPG-1:0]     out_b,
  output logic [BW-1:0]      bc_r,
  output logic [BW-1:0]      bc_g,
  output logic [BW-1:0]      bc_b
);
  localparam int NCH = 3 * CPG;
  localparam logic [GW-1:0] TOP = '1;

  logic [NCH*GW-1:0] gs_q;
  logic              blank_q, repeat_q, ext_q, rise_q;
  logic              sck_q;
  logic [GW-1:0]     cnt;
  logic              done;
  logic              tick;
  logic [NCH-1:0]    raw;
  logic [CPG-1:0]    r_q, g_d1, g_q, b_d1, b_d2, b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs_q     <= '0;
      bc_r     <= '0;
      bc_g     <= '0;
      bc_b     <= '0;
      blank_q  <= 1'b1;
      repeat_q <= 1'b0;
      ext_q    <= 1'b0;
      rise_q   <= 1'b1;
    end else if (latch_stb) begin
      gs_q     <= gs_in;
      bc_r     <= bc_in[BW-1:0];
      bc_g     <= bc_in[2*BW-1:BW];
      bc_b     <= bc_in[3*BW-1:2*BW];
      blank_q  <= ctl_blank;
      repeat_q <= ctl_repeat;
      ext_q    <= ctl_extclk;
      rise_q   <= ctl_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_in;
  end

  assign tick = ext_q ? (rise_q ? (sck_in & ~sck_q) : (~sck_in & sck_q))
                      : osc_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (latch_stb || blank_q) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (tick && !done) begin
      if (cnt == TOP) begin
        if (repeat_q) cnt <= '0;
        else          done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign raw[i] = !blank_q && !done && (cnt < gs_q[i*GW +: GW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q  <= '0;
      g_d1 <= '0;
      g_q  <= '0;
      b_d1 <= '0;
      b_d2 <= '0;
      b_q  <= '0;
    end else begin
      r_q  <= raw[CPG-1:0];
      g_d1 <= raw[2*CPG-1:CPG];
      g_q  <= g_d1;
      b_d1 <= raw[3*CPG-1:2*CPG];
      b_d2 <= b_d1;
      b_q  <= b_d2;
    end
  end

  assign out_r = r_q & {CPG{~ovt}};
  assign out_g = g_q & {CPG{~ovt}};
  assign out_b = b_q & {CPG{~ovt}};
endmodule

// File: rtl/gs_pwm12_chk.sv
`timescale 1ns/1ps
module gs_pwm12_chk #(
  parameter int CPG = 4,
  parameter int GW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           latch_stb,
  input logic           ovt,
  input logic           tick,
  input logic           blank_q,
  input logic           repeat_q,
  input logic           done,
  input logic [GW-1:0]  cnt,
  input logic [CPG-1:0] out_r,
  input logic [CPG-1:0] out_g,
  input logic [CPG-1:0] out_b
);
  localparam logic [GW-1:0] TOP = '1;

  p_load_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> (cnt == '0 && !done));

  p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q |=> (cnt == '0));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_stb && !blank_q && !done && tick && cnt != TOP)
      |=> (cnt == $past(cnt) + 1'b1));

  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !latch_stb && !blank_q) |=> (done && cnt == TOP));

  p_done_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done) && $past(done, 2) && $past(done, 3))
      |-> (out_r == '0 && out_g == '0 && out_b == '0));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (repeat_q && !blank_q && !latch_stb && !done && tick && cnt == TOP)
      |=> (cnt == '0 && !done));

  p_ovt_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovt |-> (out_r == '0 && out_g == '0 && out_b == '0));
endmodule

bind gs_pwm12 gs_pwm12_chk #(.CPG(CPG), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_stb(latch_stb), .ovt(ovt), .tick(tick),
  .blank_q(blank_q), .repeat_q(repeat_q), .done(done), .cnt(cnt),
  .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/gs_pwm12_tb_top.sv
`timescale 1ns/1ps
module gs_pwm12_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 190000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         latch_stb = 1'b0;
  logic [191:0] gs_in = '0;
  logic [20:0]  bc_in = '0;
  logic         ctl_blank = 1'b0, ctl_repeat = 1'b0, ctl_extclk = 1'b0, ctl_rise = 1'b0;
  logic         osc_tick = 1'b0, sck_in = 1'b0, ovt = 1'b0;
  logic [3:0]   out_r, out_g, out_b;
  logic [6:0]   bc_r, bc_g, bc_b;

  int total = 0;
  int bad = 0;

  gs_pwm12 dut_i (
    .clk(clk), .rst_n(rst_n), .latch_stb(latch_stb), .gs_in(gs_in), .bc_in(bc_in),
    .ctl_blank(ctl_blank), .ctl_repeat(ctl_repeat), .ctl_extclk(ctl_extclk),
    .ctl_rise(ctl_rise), .osc_tick(osc_tick), .sck_in(sck_in), .ovt(ovt),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .bc_r(bc_r), .bc_g(bc_g), .bc_b(bc_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {gs base (channel i gets base+i), oscillator ticks, expected {b,g,r}}
  localparam logic [43:0] VEC [6] = '{
    {16'd0,   16'd0,   12'hFFE},
    {16'd5,   16'd8,   12'hFF0},
    {16'd10,  16'd3,   12'hFFF},
    {16'd2,   16'd20,  12'h000},
    {16'd100, 16'd105, 12'hFC0},
    {16'd7,   16'd17,  12'h800}
  };

  function automatic logic [191:0] fill(input logic [15:0] base, input bit inc);
    logic [191:0] v;
    for (int i = 0; i < 12; i++) v[i*16 +: 16] = inc ? base + 16'(i) : base;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [11:0] exp);
    logic [11:0] got;
    got = {out_b, out_g, out_r};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_val(input string tag, input logic [20:0] got, input logic [20:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [191:0] gs, input logic blank, input logic rpt,
                      input logic ext, input logic rise);
    gs_in = gs; ctl_blank = blank; ctl_repeat = rpt; ctl_extclk = ext; ctl_rise = rise;
    latch_stb = 1'b1;
    @(negedge clk);
    latch_stb = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      osc_tick = 1'b1;
      repeat (n) @(negedge clk);
      osc_tick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs after reset", 12'h000);
    chk_val("R1 brightness after reset", {bc_b, bc_g, bc_r}, 21'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: brightness capture and export
    bc_in = {7'h7F, 7'h15, 7'h2A};
    load(fill(16'd0, 1'b0), 1'b0, 1'b0, 1'b0, 1'b0);
    chk_val("R2 brightness export", {bc_b, bc_g, bc_r}, {7'h7F, 7'h15, 7'h2A});

    // R3: comparator table
    for (int k = 0; k < 6; k++) begin
      load(fill(VEC[k][43:28], 1'b1), 1'b0, 1'b0, 1'b0, 1'b0);
      ticks(int'(VEC[k][27:12]));
      settle();
      chk($sformatf("R3 vector %0d", k), VEC[k][11:0]);
    end

    // R4: suppression
    load(fill(16'hFFFF, 1'b0), 1'b1, 1'b0, 1'b0, 1'b0);
    settle();
    chk("R4 blank outputs off", 12'h000);
    ticks(4);
    settle();
    chk("R4 blank ignores ticks", 12'h000);

    // R10: stagger
    load(fill(16'd5, 1'b0), 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(5);
    @(negedge clk); chk("R10 red first", 12'hFF0);
    @(negedge clk); chk("R10 green second", 12'hF00);
    @(negedge clk); chk("R10 blue third", 12'h000);

    // R9: over-temperature
    load(fill(16'hFFFF, 1'b0), 1'b0, 1'b0, 1'b0, 1'b0);
    settle();
    ovt = 1'b1; #1;
    chk("R9 ovt forces off", 12'h000);
    @(negedge clk);
    ovt = 1'b0; #1;
    chk("R9 ovt released", 12'hFFF);

    // R5/R6: external clock, rising edge
    load(fill(16'd2, 1'b0), 1'b0, 1'b0, 1'b1, 1'b1);
    ticks(5);
    settle();
    chk("R5 oscillator ignored", 12'hFFF);
    for (int p = 0; p < 2; p++) begin
      sck_in = 1'b1; @(negedge clk);
      sck_in = 1'b0; @(negedge clk);
    end
    settle();
    chk("R5 external rising edges counted", 12'h000);

    // R6: falling edge
    load(fill(16'd1, 1'b0), 1'b0, 1'b0, 1'b1, 1'b0);
    sck_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 rising edge ignored", 12'hFFF);
    sck_in = 1'b0;
    @(negedge clk);
    settle();
    chk("R6 falling edge counted", 12'h000);

    // R8: repeat wrap
    load(fill(16'hFFFF, 1'b0), 1'b0, 1'b1, 1'b0, 1'b0);
    ticks(65534);
    settle();
    chk("R3 FFFF on at 65534", 12'hFFF);
    ticks(1);
    settle();
    chk("R3 FFFF off at 65535", 12'h000);
    ticks(1);
    settle();
    chk("R8 wrap restarts period", 12'hFFF);

    // R7: single period
    load(fill(16'hFFFF, 1'b0), 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(65536);
    settle();
    chk("R7 stopped after period", 12'h000);
    ticks(5);
    settle();
    chk("R7 stays stopped", 12'h000);
    load(fill(16'hFFFF, 1'b0), 1'b0, 1'b0, 1'b0, 1'b0);
    settle();
    chk("R7 load restarts", 12'hFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule